// File: doc/BRIEF.md
# Priority crossbar pin allocator

This block places the signals of a group of on-chip digital peripherals (two UARTs, an SPI port, an SMBus port, a six-channel capture/compare unit with an external count input, three comparator outputs, five timers with their external inputs, two external interrupt inputs, a clock output and an ADC start input) onto a bank of general-purpose pins. There are 32 signal slots, ranked by a fixed priority. Each enabled signal takes the lowest pin that no higher-priority signal has taken. Enabling one peripheral therefore moves every lower-ranked peripheral to later pins.

Four 8-bit crossbar configuration bytes hold the peripheral enables, and a per-port latch and a per-port direction byte serve pins that no peripheral claims. Software writes and reads all of them over a small register bus. A 3-wire flag from the SPI port removes the slave-select signal from the allocation. The pin map is computed combinationally from the registered bytes. Each claimed pin carries its owner's output value and output enable. Each signal's routed input is taken from the pad of its pin.

Top module: `pin_xbar`

## Requirements
- R1: After reset every configuration byte reads 0x00, every latch byte reads 0xFF and every direction byte reads 0x00. So every pad drives 1 with its output enable low, and every routed input reads 1.
- R2: Register addresses are: 0..3 configuration bytes cfg0..cfg3, 4+k the latch byte of port k (pins 8k..8k+7), 8+k the direction byte of port k. Addresses with no register read 0x00. A write is visible on the read port, and in the pin map, from the rising clock edge that samples it, and not before.
- R3: Signal slots in priority order (index 0 highest): 0 U0_TX, 1 U0_RX, 2 SPI_CLK, 3 SPI_MISO, 4 SPI_MOSI, 5 SPI_SEL, 6 SMB_DAT, 7 SMB_CLK, 8 U1_TX, 9 U1_RX, 10..15 CAP0..CAP5, 16 CAP_CNT, 17 CMP0, 18 CMP1, 19 CMP2, 20 TM0, 21 IRQ0, 22 TM1, 23 IRQ1, 24 TM2, 25 TM2_EX, 26 TM3, 27 TM3_EX, 28 TM4, 29 TM4_EX, 30 CLK_OUT, 31 ADC_START. An enabled signal sits on the pin numbered by the count of enabled signals ranked above it.
- R4: Enable bits. cfg0: [2] UART0 (both U0 slots), [1] SPI (its slots), [0] SMBus (both SMB slots), [5:3] capture count, [6] CAP_CNT, [7] CMP0. cfg1: [0] CMP1, [1] TM0, [2] IRQ0, [3] TM1, [4] IRQ1, [5] TM2, [6] TM2_EX, [7] CLK_OUT. cfg2: [2] UART1, [3] TM4, [4] TM4_EX. cfg3: [0] TM3, [1] TM3_EX, [2] ADC_START, [3] CMP2. All other bits are stored but enable nothing.
- R5: When cfg0[2] is 1, U0_TX sits on pin 0 and U0_RX on pin 1, whatever else is enabled.
- R6: With the 3-wire flag high, SPI_SEL gets no pin, and every signal below it moves up one pin.
- R7: A capture count N enables CAP0..CAP(N-1). Values 7 are treated as 6.
- R8: An enabled signal whose pin index would reach the pin count gets no pin, and its routed input reads 1.
- R9: A pin no signal claims drives its latch bit, with its direction bit as output enable.
- R10: A claimed pin drives its owner's output value and output enable.
- R11: The routed input of an assigned signal equals the pad input of its pin.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | ADDR_W | Register address |
| reg_wdata_i | input | 8 | Register write data |
| reg_rdata_o | output | 8 | Register read data for reg_addr_i |
| spi_3wire_i | input | 1 | SPI port in 3-wire mode: slave select gets no pin |
| sig_out_i | input | 32 | Output value per signal slot |
| sig_oe_i | input | 32 | Output enable per signal slot |
| pad_in_i | input | NUM_PINS | Pad input values |
| pad_out_o | output | NUM_PINS | Pad output values |
| pad_oe_o | output | NUM_PINS | Pad output enables |
| sig_in_o | output | 32 | Routed input per signal slot (1 when unassigned) |

## Verification
A register write that moves the pin map and the pad-level routing of inputs and outputs can fall in the same cycle. The bench presents a configuration write and a probing pad pattern together. It then reads the routed inputs before the sampling edge, where the old map must hold, and after it, where the new map must hold. A second overlap comes from the 3-wire flag, which changes combinationally while the crossbar bytes stay fixed. The bench judges it by the pin shift of the signals below the slave select.

// File: rtl/pin_xbar_pkg.sv
package pin_xbar_pkg;
  localparam int NUM_SIGS   = 32;
  localparam int NUM_CFG    = 4;
  localparam int CAP_NUM    = 6;
  localparam int LATCH_BASE = 4;
  localparam int DIR_BASE   = 8;

  // signal slots, highest priority first
  localparam int SIG_U0_TX     = 0;
  localparam int SIG_U0_RX     = 1;
  localparam int SIG_SPI_CLK   = 2;
  localparam int SIG_SPI_MISO  = 3;
  localparam int SIG_SPI_MOSI  = 4;
  localparam int SIG_SPI_SEL   = 5;
  localparam int SIG_SMB_DAT   = 6;
  localparam int SIG_SMB_CLK   = 7;
  localparam int SIG_U1_TX     = 8;
  localparam int SIG_U1_RX     = 9;
  localparam int SIG_CAP0      = 10;
  localparam int SIG_CAP_CNT   = 16;
  localparam int SIG_CMP0      = 17;
  localparam int SIG_CMP1      = 18;
  localparam int SIG_CMP2      = 19;
  localparam int SIG_TM0       = 20;
  localparam int SIG_IRQ0      = 21;
  localparam int SIG_TM1       = 22;
  localparam int SIG_IRQ1      = 23;
  localparam int SIG_TM2       = 24;
  localparam int SIG_TM2_EX    = 25;
  localparam int SIG_TM3       = 26;
  localparam int SIG_TM3_EX    = 27;
  localparam int SIG_TM4       = 28;
  localparam int SIG_TM4_EX    = 29;
  localparam int SIG_CLK_OUT   = 30;
  localparam int SIG_ADC_START = 31;

  localparam int POS_W = $clog2(NUM_SIGS + 1);
  localparam int OWN_W = $clog2(NUM_SIGS);

  typedef logic [NUM_CFG-1:0][7:0] cfg_t;
endpackage

// File: rtl/pin_xbar_regs.sv
module pin_xbar_regs
  import pin_xbar_pkg::*;
#(
  parameter int NUM_PINS = 32,
  parameter int ADDR_W   = 4
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                we_i,
  input  logic [ADDR_W-1:0]   addr_i,
  input  logic [7:0]          wdata_i,
  output logic [7:0]          rdata_o,
  output cfg_t                cfg_o,
  output logic [NUM_PINS-1:0] gpio_latch_o,
  output logic [NUM_PINS-1:0] gpio_dir_o
);
  localparam int NUM_PORTS = NUM_PINS / 8;

  cfg_t                        cfg_q;
  logic [NUM_PORTS-1:0][7:0]   latch_q;
  logic [NUM_PORTS-1:0][7:0]   dir_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_q   <= '0;
      latch_q <= '1;
      dir_q   <= '0;
    end else if (we_i) begin
      for (int i = 0; i < NUM_CFG; i++)
        if (addr_i == ADDR_W'(i)) cfg_q[i] <= wdata_i;
      for (int q = 0; q < NUM_PORTS; q++) begin
        if (addr_i == ADDR_W'(LATCH_BASE + q)) latch_q[q] <= wdata_i;
        if (addr_i == ADDR_W'(DIR_BASE + q))   dir_q[q]   <= wdata_i;
      end
    end
  end

  always_comb begin
    rdata_o = '0;
    for (int i = 0; i < NUM_CFG; i++)
      if (addr_i == ADDR_W'(i)) rdata_o = cfg_q[i];
    for (int q = 0; q < NUM_PORTS; q++) begin
      if (addr_i == ADDR_W'(LATCH_BASE + q)) rdata_o = latch_q[q];
      if (addr_i == ADDR_W'(DIR_BASE + q))   rdata_o = dir_q[q];
    end
  end

  assign cfg_o        = cfg_q;
  assign gpio_latch_o = latch_q;
  assign gpio_dir_o   = dir_q;
endmodule

// File: rtl/pin_xbar_decode.sv
module pin_xbar_decode
  import pin_xbar_pkg::*;
(
  input  cfg_t                cfg_i,
  input  logic                spi_3wire_i,
  output logic [NUM_SIGS-1:0] sig_en_o
);
  logic [2:0] cap_n;
  logic       unused_bits;

  assign cap_n = (cfg_i[0][5:3] > 3'(CAP_NUM)) ? 3'(CAP_NUM) : cfg_i[0][5:3];
  assign unused_bits = ^{cfg_i[2][7:5], cfg_i[2][1:0], cfg_i[3][7:4]};

  always_comb begin
    sig_en_o = '0;
    sig_en_o[SIG_U0_TX]     = cfg_i[0][2];
    sig_en_o[SIG_U0_RX]     = cfg_i[0][2];
    sig_en_o[SIG_SPI_CLK]   = cfg_i[0][1];
    sig_en_o[SIG_SPI_MISO]  = cfg_i[0][1];
    sig_en_o[SIG_SPI_MOSI]  = cfg_i[0][1];
    sig_en_o[SIG_SPI_SEL]   = cfg_i[0][1] & ~spi_3wire_i;
    sig_en_o[SIG_SMB_DAT]   = cfg_i[0][0];
    sig_en_o[SIG_SMB_CLK]   = cfg_i[0][0];
    sig_en_o[SIG_U1_TX]     = cfg_i[2][2];
    sig_en_o[SIG_U1_RX]     = cfg_i[2][2];
    for (int k = 0; k < CAP_NUM; k++)
      sig_en_o[SIG_CAP0 + k] = (3'(k) < cap_n);
    sig_en_o[SIG_CAP_CNT]   = cfg_i[0][6];
    sig_en_o[SIG_CMP0]      = cfg_i[0][7];
    sig_en_o[SIG_CMP1]      = cfg_i[1][0];
    sig_en_o[SIG_CMP2]      = cfg_i[3][3];
    sig_en_o[SIG_TM0]       = cfg_i[1][1];
    sig_en_o[SIG_IRQ0]      = cfg_i[1][2];
    sig_en_o[SIG_TM1]       = cfg_i[1][3];
    sig_en_o[SIG_IRQ1]      = cfg_i[1][4];
    sig_en_o[SIG_TM2]       = cfg_i[1][5];
    sig_en_o[SIG_TM2_EX]    = cfg_i[1][6];
    sig_en_o[SIG_TM3]       = cfg_i[3][0];
    sig_en_o[SIG_TM3_EX]    = cfg_i[3][1];
    sig_en_o[SIG_TM4]       = cfg_i[2][3];
    sig_en_o[SIG_TM4_EX]    = cfg_i[2][4];
    sig_en_o[SIG_CLK_OUT]   = cfg_i[1][7];
    sig_en_o[SIG_ADC_START] = cfg_i[3][2];
  end
endmodule

// File: rtl/pin_xbar_alloc.sv
module pin_xbar_alloc
  import pin_xbar_pkg::*;
#(
  parameter int NUM_PINS = 32
) (
  input  logic [NUM_SIGS-1:0]             sig_en_i,
  output logic [NUM_SIGS-1:0]             sig_asg_o,
  output logic [NUM_SIGS-1:0][POS_W-1:0]  sig_pos_o,
  output logic [NUM_PINS-1:0]             pin_hit_o,
  output logic [NUM_PINS-1:0][OWN_W-1:0]  pin_own_o
);
  logic [POS_W-1:0] cnt;

  // running count of enabled higher-priority slots
  always_comb begin
    cnt = '0;
    for (int s = 0; s < NUM_SIGS; s++) begin
      sig_pos_o[s] = cnt;
      sig_asg_o[s] = sig_en_i[s] && (cnt < POS_W'(NUM_PINS));
      if (sig_en_i[s]) cnt = cnt + 1'b1;
    end
  end

  always_comb begin
    for (int p = 0; p < NUM_PINS; p++) begin
      pin_hit_o[p] = 1'b0;
      pin_own_o[p] = '0;
      for (int s = 0; s < NUM_SIGS; s++) begin
        if (sig_asg_o[s] && sig_pos_o[s] == POS_W'(p)) begin
          pin_hit_o[p] = 1'b1;
          pin_own_o[p] = OWN_W'(s);
        end
      end
    end
  end
endmodule

// File: rtl/pin_xbar.sv
module pin_xbar
  import pin_xbar_pkg::*;
#(
  parameter int NUM_PINS = 32,
  parameter int ADDR_W   = 4
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                reg_we_i,
  input  logic [ADDR_W-1:0]   reg_addr_i,
  input  logic [7:0]          reg_wdata_i,
  output logic [7:0]          reg_rdata_o,
  input  logic                spi_3wire_i,
  input  logic [31:0]         sig_out_i,
  input  logic [31:0]         sig_oe_i,
  input  logic [NUM_PINS-1:0] pad_in_i,
  output logic [NUM_PINS-1:0] pad_out_o,
  output logic [NUM_PINS-1:0] pad_oe_o,
  output logic [31:0]         sig_in_o
);
  cfg_t                             xbr_q;
  logic [NUM_PINS-1:0]              gpio_latch;
  logic [NUM_PINS-1:0]              gpio_dir;
  logic [NUM_SIGS-1:0]              sig_en;
  logic [NUM_SIGS-1:0]              sig_asg;
  logic [NUM_SIGS-1:0][POS_W-1:0]   sig_pos;
  logic [NUM_PINS-1:0]              pin_hit;
  logic [NUM_PINS-1:0][OWN_W-1:0]   pin_own;

  pin_xbar_regs #(.NUM_PINS(NUM_PINS), .ADDR_W(ADDR_W)) u_regs (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .we_i         (reg_we_i),
    .addr_i       (reg_addr_i),
    .wdata_i      (reg_wdata_i),
    .rdata_o      (reg_rdata_o),
    .cfg_o        (xbr_q),
    .gpio_latch_o (gpio_latch),
    .gpio_dir_o   (gpio_dir)
  );

  pin_xbar_decode u_decode (
    .cfg_i       (xbr_q),
    .spi_3wire_i (spi_3wire_i),
    .sig_en_o    (sig_en)
  );

  pin_xbar_alloc #(.NUM_PINS(NUM_PINS)) u_alloc (
    .sig_en_i  (sig_en),
    .sig_asg_o (sig_asg),
    .sig_pos_o (sig_pos),
    .pin_hit_o (pin_hit),
    .pin_own_o (pin_own)
  );

  always_comb begin
    for (int p = 0; p < NUM_PINS; p++) begin
      pad_out_o[p] = pin_hit[p] ? sig_out_i[pin_own[p]] : gpio_latch[p];
      pad_oe_o[p]  = pin_hit[p] ? sig_oe_i[pin_own[p]]  : gpio_dir[p];
    end
  end

  // unassigned slots idle high
  always_comb begin
    sig_in_o = '1;
    for (int p = 0; p < NUM_PINS; p++)
      if (pin_hit[p]) sig_in_o[pin_own[p]] = pad_in_i[p];
  end
endmodule

// File: rtl/pin_xbar_chk.sv
module pin_xbar_chk
  import pin_xbar_pkg::*;
#(
  parameter int NUM_PINS = 32,
  parameter int ADDR_W   = 4
) (
  input logic                            clk_i,
  input logic                            rst_ni,
  input logic                            reg_we_i,
  input logic [ADDR_W-1:0]               reg_addr_i,
  input logic [7:0]                      reg_wdata_i,
  input logic                            spi_3wire_i,
  input cfg_t                            xbr_q,
  input logic [NUM_PINS-1:0]             gpio_dir,
  input logic [NUM_SIGS-1:0]             sig_en,
  input logic [NUM_SIGS-1:0]             sig_asg,
  input logic [NUM_SIGS-1:0][POS_W-1:0]  sig_pos,
  input logic [NUM_PINS-1:0]             pin_hit,
  input logic [NUM_PINS-1:0]             pad_oe_o,
  input logic [31:0]                     sig_in_o
);
  a_r2_cfg_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_we_i && reg_addr_i == '0) |=> xbr_q[0] == $past(reg_wdata_i));

  a_r5_uart0_fixed: assert property (@(posedge clk_i) disable iff (!rst_ni)
    xbr_q[0][2] |-> (sig_asg[0] && sig_asg[1] && sig_pos[0] == '0 && sig_pos[1] == POS_W'(1)));

  a_r6_sel_dropped: assert property (@(posedge clk_i) disable iff (!rst_ni)
    spi_3wire_i |-> !sig_asg[SIG_SPI_SEL]);

  a_r7_cap_count: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(sig_en[SIG_CAP0 +: CAP_NUM]) ==
      ((xbr_q[0][5:3] > 3'(CAP_NUM)) ? CAP_NUM : int'(xbr_q[0][5:3])));

  a_r3_one_owner: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(pin_hit) == $countones(sig_asg));

  for (genvar s = 0; s < NUM_SIGS; s++) begin : g_sig
    a_r8_idle_high: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !sig_asg[s] |-> sig_in_o[s]);
  end

  for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
    a_r9_gpio_dir: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !pin_hit[p] |-> pad_oe_o[p] == gpio_dir[p]);
  end
endmodule

bind pin_xbar pin_xbar_chk #(.NUM_PINS(NUM_PINS), .ADDR_W(ADDR_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .reg_we_i    (reg_we_i),
  .reg_addr_i  (reg_addr_i),
  .reg_wdata_i (reg_wdata_i),
  .spi_3wire_i (spi_3wire_i),
  .xbr_q       (xbr_q),
  .gpio_dir    (gpio_dir),
  .sig_en      (sig_en),
  .sig_asg     (sig_asg),
  .sig_pos     (sig_pos),
  .pin_hit     (pin_hit),
  .pad_oe_o    (pad_oe_o),
  .sig_in_o    (sig_in_o)
);

// File: tb/pin_xbar_bench.sv
`timescale 1ns/1ps
module pin_xbar_bench;
  localparam int NP  = 24;
  localparam int AW  = 4;
  localparam real TCK = 8.0;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic          reg_we = 1'b0;
  logic [AW-1:0] reg_addr = '0;
  logic [7:0]    reg_wdata = '0;
  logic [7:0]    reg_rdata;
  logic          w3 = 1'b0;
  logic [31:0]   sig_out = '0;
  logic [31:0]   sig_oe = '0;
  logic [NP-1:0] pad_in = '1;
  logic [NP-1:0] pad_out;
  logic [NP-1:0] pad_oe;
  logic [31:0]   sig_in;

  int n_chk = 0;
  int n_fail = 0;

  logic [7:0]    sh_cfg [4];
  logic [NP-1:0] sh_latch;
  logic [NP-1:0] sh_dir;
  int            exp_pin [32];
  int            meas [32];

  always #(TCK / 2) clk_i = ~clk_i;

  pin_xbar #(.NUM_PINS(NP), .ADDR_W(AW)) u_pin_xbar (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .reg_we_i    (reg_we),
    .reg_addr_i  (reg_addr),
    .reg_wdata_i (reg_wdata),
    .reg_rdata_o (reg_rdata),
    .spi_3wire_i (w3),
    .sig_out_i   (sig_out),
    .sig_oe_i    (sig_oe),
    .pad_in_i    (pad_in),
    .pad_out_o   (pad_out),
    .pad_oe_o    (pad_oe),
    .sig_in_o    (sig_in)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr(input int a, input logic [7:0] d);
    @(negedge clk_i);
    reg_we = 1'b1; reg_addr = AW'(a); reg_wdata = d;
    @(negedge clk_i);
    reg_we = 1'b0;
    if (a < 4) sh_cfg[a] = d;
    else if (a >= 4 && a < 4 + NP / 8) sh_latch[(a - 4) * 8 +: 8] = d;
    else if (a >= 8 && a < 8 + NP / 8) sh_dir[(a - 8) * 8 +: 8] = d;
  endtask

  task automatic wr_cfg(input logic [7:0] c0, c1, c2, c3);
    wr(0, c0); wr(1, c1); wr(2, c2); wr(3, c3);
  endtask

  // reference priority walk built from the requirement text
  function automatic void ref_map();
    bit [31:0] e;
    int n, cnt;
    e = '0;
    e[0] = sh_cfg[0][2];  e[1] = sh_cfg[0][2];
    e[2] = sh_cfg[0][1];  e[3] = sh_cfg[0][1]; e[4] = sh_cfg[0][1];
    e[5] = sh_cfg[0][1] & ~w3;
    e[6] = sh_cfg[0][0];  e[7] = sh_cfg[0][0];
    e[8] = sh_cfg[2][2];  e[9] = sh_cfg[2][2];
    n = int'(sh_cfg[0][5:3]);
    if (n > 6) n = 6;
    for (int k = 0; k < 6; k++) e[10 + k] = (k < n);
    e[16] = sh_cfg[0][6]; e[17] = sh_cfg[0][7]; e[18] = sh_cfg[1][0];
    e[19] = sh_cfg[3][3]; e[20] = sh_cfg[1][1]; e[21] = sh_cfg[1][2];
    e[22] = sh_cfg[1][3]; e[23] = sh_cfg[1][4]; e[24] = sh_cfg[1][5];
    e[25] = sh_cfg[1][6]; e[26] = sh_cfg[3][0]; e[27] = sh_cfg[3][1];
    e[28] = sh_cfg[2][3]; e[29] = sh_cfg[2][4]; e[30] = sh_cfg[1][7];
    e[31] = sh_cfg[3][2];
    cnt = 0;
    for (int s = 0; s < 32; s++) begin
      exp_pin[s] = -1;
      if (e[s]) begin
        if (cnt < NP) exp_pin[s] = cnt;
        cnt++;
      end
    end
  endfunction

  // locate each signal by pulling one pad low at a time
  task automatic measure();
    for (int s = 0; s < 32; s++) meas[s] = -1;
    for (int p = 0; p < NP; p++) begin
      pad_in = ~(NP'(1) << p);
      #1;
      for (int s = 0; s < 32; s++) if (sig_in[s] == 1'b0) meas[s] = p;
    end
    pad_in = '1;
    #1;
  endtask

  task automatic check_map(input string req);
    ref_map();
    measure();
    for (int s = 0; s < 32; s++) chk(meas[s] == exp_pin[s], req, meas[s], exp_pin[s]);
  endtask

  task automatic check_drive(input string req);
    logic [NP-1:0] eo, ee;
    ref_map();
    eo = sh_latch; ee = sh_dir;
    for (int s = 0; s < 32; s++)
      if (exp_pin[s] >= 0) begin
        eo[exp_pin[s]] = sig_out[s];
        ee[exp_pin[s]] = sig_oe[s];
      end
    #1;
    chk(pad_out == eo, req, 32'(pad_out), 32'(eo));
    chk(pad_oe == ee, req, 32'(pad_oe), 32'(ee));
  endtask

  task automatic check_route(input string req);
    logic [31:0] ei;
    ref_map();
    pad_in = NP'($urandom);
    #1;
    for (int s = 0; s < 32; s++) ei[s] = (exp_pin[s] >= 0) ? pad_in[exp_pin[s]] : 1'b1;
    chk(sig_in == ei, req, sig_in, ei);
    pad_in = '1;
    #1;
  endtask

  task automatic t_reset();
    #1;
    chk(pad_out == '1, "R1 pad_out", 32'(pad_out), 32'(NP'('1)));
    chk(pad_oe == '0, "R1 pad_oe", 32'(pad_oe), 0);
    chk(sig_in == '1, "R1 sig_in", sig_in, 32'hffff_ffff);
    reg_addr = 4'd0; #1; chk(reg_rdata == 8'h00, "R1 cfg0", 32'(reg_rdata), 0);
    reg_addr = 4'd4; #1; chk(reg_rdata == 8'hff, "R1 latch0", 32'(reg_rdata), 32'hff);
    reg_addr = 4'd8; #1; chk(reg_rdata == 8'h00, "R1 dir0", 32'(reg_rdata), 0);
  endtask

  task automatic t_readback();
    // write and probe pad 0 in the same cycle: old map until the edge
    @(negedge clk_i);
    reg_we = 1'b1; reg_addr = 4'd0; reg_wdata = 8'h04;
    pad_in = ~NP'(1);
    #1;
    chk(sig_in[0] == 1'b1, "R2 before edge", 32'(sig_in[0]), 1);
    chk(reg_rdata == 8'h00, "R2 rdata before edge", 32'(reg_rdata), 0);
    @(negedge clk_i);
    reg_we = 1'b0;
    sh_cfg[0] = 8'h04;
    #1;
    chk(sig_in[0] == 1'b0, "R2 after edge", 32'(sig_in[0]), 0);
    chk(reg_rdata == 8'h04, "R2 rdata after edge", 32'(reg_rdata), 4);
    pad_in = '1;
    wr(1, 8'hA5); wr(2, 8'hE7); wr(3, 8'h3C); wr(9, 8'h5A);
    reg_addr = 4'd1; #1; chk(reg_rdata == 8'hA5, "R2 cfg1", 32'(reg_rdata), 32'ha5);
    reg_addr = 4'd2; #1; chk(reg_rdata == 8'hE7, "R2 cfg2 spare bits", 32'(reg_rdata), 32'he7);
    reg_addr = 4'd3; #1; chk(reg_rdata == 8'h3C, "R2 cfg3", 32'(reg_rdata), 32'h3c);
    reg_addr = 4'd9; #1; chk(reg_rdata == 8'h5A, "R2 dir1", 32'(reg_rdata), 32'h5a);
    reg_addr = 4'd7; #1; chk(reg_rdata == 8'h00, "R2 empty addr", 32'(reg_rdata), 0);
    check_map("R4 bitmap");
  endtask

  task automatic t_uart0();
    wr_cfg(8'hFF, 8'hFF, 8'hFF, 8'hFF);
    measure();
    chk(meas[0] == 0, "R5 tx pin", meas[0], 0);
    chk(meas[1] == 1, "R5 rx pin", meas[1], 1);
    wr_cfg(8'h04, 8'h00, 8'h00, 8'h00);
    measure();
    chk(meas[0] == 0 && meas[1] == 1, "R5 alone", meas[1], 1);
  endtask

  task automatic t_three_wire();
    wr_cfg(8'h07, 8'h00, 8'h00, 8'h00);
    w3 = 1'b0;
    measure();
    chk(meas[5] == 5, "R6 sel 4-wire", meas[5], 5);
    chk(meas[6] == 6, "R6 sda 4-wire", meas[6], 6);
    w3 = 1'b1;
    measure();
    chk(meas[5] == -1, "R6 sel 3-wire", meas[5], -1);
    chk(meas[6] == 5, "R6 sda moved up", meas[6], 5);
    check_map("R6 map");
    w3 = 1'b0;
  endtask

  task automatic t_cap();
    wr_cfg(8'h78, 8'h00, 8'h00, 8'h00); // count 7, count input on
    measure();
    chk(meas[15] == 5, "R7 cap5 clamp", meas[15], 5);
    chk(meas[16] == 6, "R7 cnt after caps", meas[16], 6);
    wr_cfg(8'h18, 8'h00, 8'h00, 8'h00); // count 3
    measure();
    chk(meas[12] == 2, "R7 cap2", meas[12], 2);
    chk(meas[13] == -1, "R7 cap3 off", meas[13], -1);
  endtask

  task automatic t_overflow();
    wr_cfg(8'hFF, 8'hFF, 8'hFF, 8'hFF);
    w3 = 1'b0;
    check_map("R8 map");
    pad_in = '0;
    #1;
    chk(sig_in[31:24] == 8'hFF, "R8 idle high", 32'(sig_in[31:24]), 32'hff);
    chk(sig_in[23:0] == 24'h0, "R11 low pads", 32'(sig_in[23:0]), 0);
    pad_in = '1;
  endtask

  task automatic t_gpio();
    wr_cfg(8'h04, 8'h00, 8'h00, 8'h00);
    wr(4, 8'h5A); wr(5, 8'hC3); wr(6, 8'h0F);
    wr(8, 8'hF0); wr(9, 8'h3C); wr(10, 8'hAA);
    sig_out = '0; sig_oe = '1;
    check_drive("R9 gpio fallback");
    wr_cfg(8'h00, 8'h00, 8'h00, 8'h00);
    check_drive("R9 all gpio");
  endtask

  task automatic t_random();
    for (int it = 0; it < 40; it++) begin
      wr_cfg(8'($urandom), 8'($urandom), 8'($urandom), 8'($urandom));
      w3 = 1'($urandom);
      sig_out = $urandom; sig_oe = $urandom;
      check_map("R3 walk");
      check_drive("R10 drive");
      check_route("R11 route");
    end
    w3 = 1'b0;
  endtask

  initial begin
    for (int i = 0; i < 4; i++) sh_cfg[i] = 8'h00;
    sh_latch = '1; sh_dir = '0;
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    t_reset();
    t_readback();
    t_uart0();
    t_three_wire();
    t_cap();
    t_overflow();
    t_gpio();
    t_random();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #(TCK * 100000);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule